// File: doc/BRIEF.md
# Programmable Trigger Command Sequencer

This block runs a short program of 8-bit commands held in a parallel command queue. Each clock cycle it executes the command at the current step. A command can stall until a chosen trigger input shows a rising or falling edge. It can stall until an internal delay timer reaches a programmed limit, or it can fire a one-cycle pulse on one of a bank of trigger output lines. It can also redirect the step pointer. The current step index is visible on a port.

A typical program watches the edge of a source PWM, waits a timer delay and pulses the sync input of a second PWM. It then jumps back to the first step, so the second PWM runs as a phase-shifted copy of the first. At an 8 MHz clock, a limit of 1000 gives roughly 0.125 ms of phase shift. Execution starts only after the block is enabled and then given a start request. It always begins at step 0.

Each command byte holds the opcode in bits [7:4] and the operand in bits [3:0]. Step k occupies `cmd_queue[8k+7:8k]`.

Top module: `trig_seq`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `step_idx` is 0 and `trig_out` is all zeros.
- R2: Execution starts only when `start` is sampled high while `en` is high and the sequencer is idle. `en` high without `start`, or `start` with `en` low, leaves `step_idx` at 0 and emits no pulse.
- R3: Opcode 2 waits for a rising edge and opcode 3 waits for a falling edge. In both cases the operand selects the trigger input. The step advances at the clock edge that first samples the new input level, and stays put until then.
- R4: An edge is the difference between the sampled input and its value one cycle earlier. One transition therefore releases at most one wait, and a level held high releases nothing further.
- R5: Opcode 1 with operand 4'b1000 is a timer wait. The timer restarts from zero every time the step is entered, and the step is held for exactly `tmr_limit`+1 cycles. A limit of 0 gives one cycle.
- R6: Opcode 1 with any other operand advances after one cycle.
- R7: Opcodes 4 and 5 emit a trigger and advance. The output line number is {opcode[0], operand}, so 0 to 31. In the cycle after the command executes, `trig_out` has exactly that bit set, for one cycle. Lines at or above `NUM_OUT` produce no pulse.
- R8: Opcode 6 sets the step to the operand modulo `NUM_STEPS` in one cycle.
- R9: Opcodes 0 and 7 to 15 do nothing and advance. The step after the last one wraps to 0.
- R10: When `en` is low, the next cycle has `step_idx` at 0 and no pulse. After `en` returns high, a new start request is needed.
- R11: In a program of edge wait, timer wait, trigger and jump to 0, the pulse appears `tmr_limit`+2 cycles after the clock edge that detects the input edge, and the program loops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Enable; low forces the idle state |
| start | input | 1 | Start request, taken while enabled and idle |
| cmd_queue | input | 8*NUM_STEPS | Command bytes, step k in bits [8k+7:8k] |
| tmr_limit | input | TMR_W | Timer-wait limit |
| trig_in | input | NUM_IN | Trigger inputs watched by edge waits |
| trig_out | output | NUM_OUT | One-cycle trigger pulses |
| step_idx | output | $clog2(NUM_STEPS) | Current step |

## Verification
The bench builds the block with `NUM_STEPS`=4, `TMR_W`=8, `NUM_IN`=2 and `NUM_OUT`=32. With four steps, a jump operand of 5 lands on step 1, and a program without a jump visibly wraps to step 0. Thirty-two output lines put both halves of the extended line number within reach (lines 0, 1, 3, 26 and 31). A short timer width keeps limits of 0, 2 and 5 cheap to sweep within one looping program.

// File: rtl/trig_seq_pkg.sv
package trig_seq_pkg;

  typedef enum logic [3:0] {
    OP_NOP     = 4'h0,
    OP_CTRL    = 4'h1,
    OP_WRISE   = 4'h2,
    OP_WFALL   = 4'h3,
    OP_TRIG_LO = 4'h4,
    OP_TRIG_HI = 4'h5,
    OP_JUMP    = 4'h6
  } op_e;

  localparam logic [3:0] CTRL_TMR0_WAIT = 4'b1000;

  typedef struct packed {
    logic [3:0] op;
    logic [3:0] arg;
  } cmd_t;

  // output line number: opcode LSB extends the 4-bit operand
  function automatic logic [4:0] trig_line(input cmd_t c);
    return {c.op[0], c.arg};
  endfunction

  function automatic logic is_trig(input cmd_t c);
    return (c.op == OP_TRIG_LO) || (c.op == OP_TRIG_HI);
  endfunction

  function automatic logic is_tmr_wait(input cmd_t c);
    return (c.op == OP_CTRL) && (c.arg == CTRL_TMR0_WAIT);
  endfunction

endpackage

// File: rtl/trig_seq_edge.sv
module trig_seq_edge #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] sig,
  output logic [N-1:0] rise,
  output logic [N-1:0] fall
);
  logic [N-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= sig;
  end

  assign rise = sig & ~prev_q;
  assign fall = ~sig & prev_q;
endmodule

// File: rtl/trig_seq_timer.sv
module trig_seq_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         arm,
  input  logic [W-1:0] limit,
  output logic         done
);
  logic         active_q;
  logic [W-1:0] count_q;

  function automatic logic reached(input logic act, input logic [W-1:0] cnt,
                                   input logic [W-1:0] lim);
    return act ? (cnt >= lim) : (lim == '0);
  endfunction

  assign done = arm && reached(active_q, count_q, limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      count_q  <= '0;
    end else if (!arm || done) begin
      active_q <= 1'b0;
      count_q  <= '0;
    end else if (!active_q) begin
      active_q <= 1'b1;
      count_q  <= W'(1);
    end else begin
      count_q  <= count_q + W'(1);
    end
  end
endmodule

// File: rtl/trig_seq.sv
module trig_seq
  import trig_seq_pkg::*;
#(
  parameter int NUM_STEPS = 8,
  parameter int TMR_W     = 16,
  parameter int NUM_IN    = 16,
  parameter int NUM_OUT   = 32,
  localparam int IW       = $clog2(NUM_STEPS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   en,
  input  logic                   start,
  input  logic [8*NUM_STEPS-1:0] cmd_queue,
  input  logic [TMR_W-1:0]       tmr_limit,
  input  logic [NUM_IN-1:0]      trig_in,
  output logic [NUM_OUT-1:0]     trig_out,
  output logic [IW-1:0]          step_idx
);
  cmd_t              q_arr [NUM_STEPS];
  cmd_t              cur;
  logic              running;
  logic              exec;
  logic [NUM_IN-1:0] rise, fall;
  logic              edge_wait, edge_hit;
  logic              tmr_wait, tmr_done;
  logic              fire, jump_take;
  logic [IW-1:0]     jump_tgt, step_nxt;
  logic [NUM_OUT-1:0] line_hot;

  for (genvar g = 0; g < NUM_STEPS; g++) begin : g_unpack
    assign q_arr[g] = cmd_queue[8*g +: 8];
  end

  function automatic logic pick(input logic [NUM_IN-1:0] v, input logic [3:0] sel);
    logic r;
    r = 1'b0;
    for (int i = 0; i < NUM_IN; i++)
      if (sel == 4'(i)) r = v[i];
    return r;
  endfunction

  function automatic logic [IW-1:0] step_inc(input logic [IW-1:0] s);
    return (s == IW'(NUM_STEPS - 1)) ? '0 : s + IW'(1);
  endfunction

  assign cur       = q_arr[step_idx];
  assign exec      = en && running;
  assign edge_wait = exec && ((cur.op == OP_WRISE) || (cur.op == OP_WFALL));
  assign edge_hit  = edge_wait &&
                     ((cur.op == OP_WRISE) ? pick(rise, cur.arg) : pick(fall, cur.arg));
  assign tmr_wait  = exec && is_tmr_wait(cur);
  assign fire      = exec && is_trig(cur) && (int'(trig_line(cur)) < NUM_OUT);
  assign jump_take = exec && (cur.op == OP_JUMP);
  assign jump_tgt  = cur.arg[IW-1:0];

  for (genvar g = 0; g < NUM_OUT; g++) begin : g_hot
    assign line_hot[g] = (trig_line(cur) == 5'(g));
  end

  trig_seq_edge #(.N(NUM_IN)) u_edge (
    .clk(clk), .rst_n(rst_n), .sig(trig_in), .rise(rise), .fall(fall)
  );

  trig_seq_timer #(.W(TMR_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .arm(tmr_wait), .limit(tmr_limit), .done(tmr_done)
  );

  always_comb begin
    step_nxt = step_inc(step_idx);
    if (edge_wait && !edge_hit)      step_nxt = step_idx;
    else if (tmr_wait && !tmr_done)  step_nxt = step_idx;
    else if (jump_take)              step_nxt = jump_tgt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running  <= 1'b0;
      step_idx <= '0;
      trig_out <= '0;
    end else if (!en) begin
      running  <= 1'b0;
      step_idx <= '0;
      trig_out <= '0;
    end else begin
      trig_out <= fire ? line_hot : '0;
      if (!running) begin
        running  <= start;
        step_idx <= '0;
      end else begin
        step_idx <= step_nxt;
      end
    end
  end
endmodule

// File: rtl/trig_seq_chk.sv
module trig_seq_chk #(
  parameter int IW      = 3,
  parameter int NUM_OUT = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               en,
  input logic               running,
  input logic [NUM_OUT-1:0] trig_out,
  input logic [IW-1:0]      step_idx,
  input logic               edge_wait,
  input logic               edge_hit,
  input logic               tmr_wait,
  input logic               tmr_done,
  input logic               fire,
  input logic               jump_take,
  input logic [IW-1:0]      jump_tgt
);
  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !running |=> trig_out == '0);

  p_edge_stall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_wait && !edge_hit) |=> $stable(step_idx));

  p_timer_stall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_wait && !tmr_done) |=> $stable(step_idx));

  p_pulse_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(trig_out));

  p_fire_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> $countones(trig_out) == 1);

  p_jump_dest_r8: assert property (@(posedge clk) disable iff (!rst_n)
    jump_take |=> step_idx == $past(jump_tgt));

  p_disable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (step_idx == '0 && trig_out == '0));
endmodule

bind trig_seq trig_seq_chk #(.IW(IW), .NUM_OUT(NUM_OUT)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .running(running), .trig_out(trig_out),
  .step_idx(step_idx), .edge_wait(edge_wait), .edge_hit(edge_hit),
  .tmr_wait(tmr_wait), .tmr_done(tmr_done), .fire(fire),
  .jump_take(jump_take), .jump_tgt(jump_tgt)
);

// File: tb/trig_seq_tb.sv
module trig_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 4;
  localparam int TW = 8;
  localparam int NI = 2;
  localparam int NO = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          en = 1'b0;
  logic          start = 1'b0;
  logic [NS*8-1:0] q = '0;
  logic [TW-1:0] lim = '0;
  logic [NI-1:0] tin = '0;
  logic [NO-1:0] tout;
  logic [1:0]    sidx;

  trig_seq #(.NUM_STEPS(NS), .TMR_W(TW), .NUM_IN(NI), .NUM_OUT(NO)) u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .start(start), .cmd_queue(q),
    .tmr_limit(lim), .trig_in(tin), .trig_out(tout), .step_idx(sidx)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 1'b0;
  int exp_line[$];
  int exp_cyc[$];

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // driver side of the scoreboard: expected pulse line and cycle
  task automatic push(input int line, input int c);
    exp_line.push_back(line);
    exp_cyc.push_back(c);
  endtask

  task automatic setup(input logic [NS*8-1:0] prog, input int limit);
    en = 1'b0;
    tick(1);
    q = prog;
    lim = TW'(limit);
    en = 1'b1;
    start = 1'b1;
    tick(1);
    start = 1'b0;
  endtask

  // monitor side: pop and compare every observed pulse
  always @(negedge clk) begin
    if (rst_n && tout != '0) begin
      int ln;
      ln = -1;
      for (int i = 0; i < NO; i++) if (tout[i]) ln = i;
      check("R7 one line per pulse", $countones(tout), 1);
      if (exp_line.size() == 0) begin
        check("R7 unexpected pulse line", ln, -1);
      end else begin
        int el, ec;
        el = exp_line.pop_front();
        ec = exp_cyc.pop_front();
        check("R7 pulse line", ln, el);
        check("R11 pulse cycle", cyc, ec);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      n_chk++;
      n_err++;
      $display("FAIL all requirements: actual=watchdog expired expected=run complete");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    int c;
    // reset state
    tick(2);
    check("R1 step in reset", int'(sidx), 0);
    check("R1 pulses in reset", int'(tout), 0);
    rst_n = 1'b1;
    tick(1);
    check("R1 step after reset", int'(sidx), 0);
    check("R1 pulses after reset", int'(tout), 0);

    // A: edge wait, timer wait, trigger 26, jump 0; limits 5, 2, 0
    setup({8'h60, 8'h5A, 8'h18, 8'h20}, 5);
    tick(3);
    check("R3 stall without edge", int'(sidx), 0);
    foreach (lim_list[k]) begin
      int lv;
      lv = lim_list[k];
      lim = TW'(lv);
      c = cyc;
      tin[0] = 1'b1;
      push(26, c + 3 + lv);
      tick(1);
      check("R3 rising edge releases", int'(sidx), 1);
      tick(lv);
      check("R5 timer still holding", int'(sidx), 1);
      tick(1);
      check("R5 timer released", int'(sidx), 2);
      tick(1);
      check("R7 trigger advances", int'(sidx), 3);
      tick(1);
      check("R8 jump to 0 loops", int'(sidx), 0);
      tin[0] = 1'b0;
      tick(2);
    end

    // B: ctrl no-op, lines 3 and 31, jump 5 wraps to 1, then disable
    setup({8'h65, 8'h5F, 8'h43, 8'h13}, 0);
    c = cyc;
    push(3, c + 2); push(31, c + 3); push(3, c + 5); push(31, c + 6);
    tick(1);
    check("R6 non-timer control advances", int'(sidx), 1);
    tick(2);
    check("R7 two triggers in a row", int'(sidx), 3);
    tick(1);
    check("R8 jump operand modulo steps", int'(sidx), 1);
    tick(2);
    en = 1'b0;
    tick(1);
    check("R10 disable clears step", int'(sidx), 0);
    tick(4);
    check("R10 stays idle while disabled", int'(sidx), 0);
    en = 1'b1;
    tick(5);
    check("R10 re-enable needs start", int'(sidx), 0);

    // C: falling-edge wait on input 1, limit 0, start rules
    en = 1'b0;
    q = {8'h60, 8'h41, 8'h18, 8'h31};
    lim = '0;
    tin = 2'b10;
    tick(1);
    en = 1'b1;
    tick(3);
    tin[1] = 1'b0;
    tick(3);
    check("R2 enabled but not started", int'(sidx), 0);
    en = 1'b0;
    start = 1'b1;
    tick(3);
    check("R2 start while disabled", int'(sidx), 0);
    start = 1'b0;
    en = 1'b1;
    tin[1] = 1'b1;
    tick(2);
    start = 1'b1;
    tick(1);
    start = 1'b0;
    tick(2);
    check("R3 falling wait holds on high level", int'(sidx), 0);
    c = cyc;
    tin[1] = 1'b0;
    push(1, c + 3);
    tick(1);
    check("R3 falling edge releases", int'(sidx), 1);
    tick(1);
    check("R5 zero limit takes one cycle", int'(sidx), 2);
    tick(1);
    check("R7 extended line 1 step", int'(sidx), 3);
    tick(1);
    check("R8 loop back", int'(sidx), 0);

    // D: held level releases one wait only; no-op wraps to 0
    tin = '0;
    setup({8'h00, 8'h40, 8'h20, 8'h20}, 0);
    tick(2);
    tin[0] = 1'b1;
    tick(1);
    check("R4 first wait released", int'(sidx), 1);
    tick(6);
    check("R4 held level releases nothing more", int'(sidx), 1);
    tin[0] = 1'b0;
    tick(2);
    check("R4 falling level ignored by rising wait", int'(sidx), 1);
    c = cyc;
    tin[0] = 1'b1;
    push(0, c + 2);
    tick(1);
    check("R4 second edge releases", int'(sidx), 2);
    tick(1);
    check("R7 trigger line 0 step", int'(sidx), 3);
    tick(1);
    check("R9 no-op last step wraps", int'(sidx), 0);
    tick(3);
    check("R4 held level after wrap", int'(sidx), 0);
    en = 1'b0;
    tick(3);
    check("R7 all expected pulses seen", exp_line.size(), 0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  int lim_list[3] = '{5, 2, 0};
endmodule